// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block turns a 3-bit bus status code into the address latch enable and four active-low command strobes: memory read, memory write, I/O read and I/O write. It has no ready or wait input. Where each bus cycle starts and ends is worked out only from changes of the status code. A bus master adds wait states by holding the status code steady, and the strobes then stay active for as long as the code is held.

A cycle starts at the rising clock edge where the status code has moved from idle to a command code. The first clock of the cycle (T1) raises ALE. The second clock (T2) starts a write strobe. A read strobe starts one clock later than a write strobe, at the third clock (T3). While the code stays unchanged the block repeats T3 as a wait state. The rising edge that sees the code leave the cycle's value releases the write strobe and enters T4. The read strobe stays active through T4, and the block then returns to idle.

Top module: `bus_cmd_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, ale_o is 0 and memr_no, memw_no, ior_no and iow_no are all 1.
- R2: A cycle starts only at a rising edge where the status sampled at the previous edge was 3'b111 and the current status is a command code. ale_o is 1 for exactly the one clock that follows that edge (T1).
- R3: For a write cycle, the matching write strobe is low from the clock after T1 until the first rising edge, at least two clocks after T1, where the status differs from the cycle's code.
- R4: For a read cycle, the matching read strobe goes low one clock later than a write strobe would and releases one clock later than a write strobe would.
- R5: Each extra clock that the code is held beyond the minimum cycle lengthens the active strobe by exactly one clock.
- R6: Command encodings: 3'b101 drives memr_no, 3'b110 drives memw_no, 3'b001 drives ior_no, 3'b010 drives iow_no. 3'b111 is idle.
- R7: Codes 3'b000, 3'b011 and 3'b100 raise neither ALE nor any strobe, and they start no cycle.
- R8: A command code that does not follow idle starts no cycle. This holds for a code present when reset is released and for a switch from one command code directly to another, which ends the running cycle without starting a new one.
- R9: At most one command strobe is low at any time, and ALE is never high together with a strobe.
- R10: Asserting rst_ni in the middle of a cycle immediately drops ALE and releases every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| status_i | input | 3 | Bus status code from the master |
| ale_o | output | 1 | Address latch enable, high during T1 |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |

## Verification
The assertions check on every cycle the properties that hold at every clock edge:
- strobes are mutually exclusive;
- ALE lasts one clock and is preceded by a command code;
- write strobes start right after ALE and read strobes two clocks after it;
- a write strobe releases only after the status leaves the write code.

Other behaviour can only be shown by the bench's scenarios:
- the exact stretch length for each hold time;
- the one-clock read lag at release;
- the silence of the non-command codes;
- the refusal to start without a preceding idle code, both after reset and on a direct switch from one command code to another;
- the abort on a mid-cycle reset.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STATUS_W = 3;
  localparam int N_CMD    = 4;
  localparam int IDX_W    = $clog2(N_CMD);

  typedef logic [STATUS_W-1:0] status_t;

  localparam status_t ST_IDLE = 3'b111;
  localparam status_t ST_MRD  = 3'b101;
  localparam status_t ST_MWR  = 3'b110;
  localparam status_t ST_IORD = 3'b001;
  localparam status_t ST_IOWR = 3'b010;
  // value held after reset so a start needs an idle sample first
  localparam status_t ST_RST  = 3'b000;

  // strobe index order: memr, memw, ior, iow
  localparam logic [IDX_W-1:0] IDX_MRD  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_MWR  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_IORD = 2'd2;
  localparam logic [IDX_W-1:0] IDX_IOWR = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4
  } phase_e;

  typedef struct packed {
    logic             valid;
    logic             is_read;
    logic [IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/bus_status_decode.sv
module bus_status_decode
  import bus_cmd_pkg::*;
(
  input  status_t status_i,
  output cmd_t    cmd_o
);
  always_comb begin
    cmd_o = '0;
    unique case (status_i)
      ST_MRD:  cmd_o = '{valid: 1'b1, is_read: 1'b1, idx: IDX_MRD};
      ST_MWR:  cmd_o = '{valid: 1'b1, is_read: 1'b0, idx: IDX_MWR};
      ST_IORD: cmd_o = '{valid: 1'b1, is_read: 1'b1, idx: IDX_IORD};
      ST_IOWR: cmd_o = '{valid: 1'b1, is_read: 1'b0, idx: IDX_IOWR};
      default: cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
  import bus_cmd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  status_t status_i,
  input  cmd_t    cmd_i,
  output phase_e  phase_o,
  output cmd_t    cmd_o
);
  phase_e  phase_q, phase_d;
  status_t prev_q;
  status_t code_q, code_d;
  cmd_t    cmd_q, cmd_d;
  logic    start;

  assign start = (prev_q == ST_IDLE) && cmd_i.valid;

  always_comb begin
    phase_d = phase_q;
    code_d  = code_q;
    cmd_d   = cmd_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_T1;
        code_d  = status_i;
        cmd_d   = cmd_i;
      end
      PH_T1: phase_d = PH_T2;
      PH_T2: phase_d = PH_T3;
      // T3 repeats as a wait state while the code is held
      PH_T3: if (status_i != code_q) phase_d = PH_T4;
      PH_T4: begin
        phase_d = PH_IDLE;
        cmd_d   = '0;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      prev_q  <= ST_RST;
      code_q  <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      phase_q <= phase_d;
      prev_q  <= status_i;
      code_q  <= code_d;
      cmd_q   <= cmd_d;
    end
  end

  assign phase_o = phase_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_cmd_pkg::*;
(
  input  phase_e           phase_i,
  input  cmd_t             cmd_i,
  output logic             ale_o,
  output logic [N_CMD-1:0] strobe_no
);
  logic rd_window, wr_window;

  assign ale_o     = (phase_i == PH_T1);
  // read window trails the write window by one clock
  assign wr_window = (phase_i == PH_T2) || (phase_i == PH_T3);
  assign rd_window = (phase_i == PH_T3) || (phase_i == PH_T4);

  for (genvar g = 0; g < N_CMD; g++) begin : g_strobe
    logic sel;
    assign sel          = cmd_i.valid && (cmd_i.idx == IDX_W'(g));
    assign strobe_no[g] = ~(sel && (cmd_i.is_read ? rd_window : wr_window));
  end
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bus_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] status_i,
  output logic       ale_o,
  output logic       memr_no,
  output logic       memw_no,
  output logic       ior_no,
  output logic       iow_no
);
  cmd_t             dec_cmd, cyc_cmd;
  phase_e           phase;
  logic [N_CMD-1:0] strobe_n;

  bus_status_decode u_dec (
    .status_i (status_i),
    .cmd_o    (dec_cmd)
  );

  bus_cycle_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .cmd_i    (dec_cmd),
    .phase_o  (phase),
    .cmd_o    (cyc_cmd)
  );

  bus_strobe_gen u_stb (
    .phase_i   (phase),
    .cmd_i     (cyc_cmd),
    .ale_o     (ale_o),
    .strobe_no (strobe_n)
  );

  assign memr_no = strobe_n[IDX_MRD];
  assign memw_no = strobe_n[IDX_MWR];
  assign ior_no  = strobe_n[IDX_IORD];
  assign iow_no  = strobe_n[IDX_IOWR];
endmodule

// File: rtl/bus_cmd_gen_chk.sv
module bus_cmd_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] status_i,
  input logic       ale_o,
  input logic       memr_no,
  input logic       memw_no,
  input logic       ior_no,
  input logic       iow_no
);
  logic rd_any, wr_any;
  assign rd_any = !memr_no || !ior_no;
  assign wr_any = !memw_no || !iow_no;

  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!memr_no, !memw_no, !ior_no, !iow_no}) <= 1);

  // R9
  ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (!rd_any && !wr_any));

  // R2
  ale_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> ($past(status_i) inside {3'b101, 3'b110, 3'b001, 3'b010}));

  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R3
  wr_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_any) |-> $past(ale_o));

  // R4
  rd_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_any) |-> $past(ale_o, 2));

  // R3
  memw_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(memw_no) |-> ($past(status_i) != 3'b110));

  // R3
  iow_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iow_no) |-> ($past(status_i) != 3'b010));
endmodule

bind bus_cmd_gen bus_cmd_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .status_i (status_i),
  .ale_o    (ale_o),
  .memr_no  (memr_no),
  .memw_no  (memw_no),
  .ior_no   (ior_no),
  .iow_no   (iow_no)
);

// File: tb/tb_bus_cmd_gen.sv
`timescale 1ns/1ps
module tb_bus_cmd_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] status_i = 3'b111;
  logic       ale_o, memr_no, memw_no, ior_no, iow_no;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [4:0] IDLE_V = 5'b01111;

  bus_cmd_gen dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .ale_o    (ale_o),
    .memr_no  (memr_no),
    .memw_no  (memw_no),
    .ior_no   (ior_no),
    .iow_no   (iow_no)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [4:0] outs();
    return {ale_o, memr_no, memw_no, ior_no, iow_no};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ale,memr_n,memw_n,ior_n,iow_n} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  // expected outputs k clocks after the code was applied; m = clock that enters T4
  function automatic logic [4:0] expect_at(logic [2:0] c, int k, int m);
    logic [4:0] v;
    bit rd, wr;
    v  = IDLE_V;
    rd = (k >= 3) && (k <= m + 1);
    wr = (k >= 2) && (k <= m);
    case (c)
      3'b101: begin v[4] = (k == 1); v[3] = ~rd; end
      3'b110: begin v[4] = (k == 1); v[2] = ~wr; end
      3'b001: begin v[4] = (k == 1); v[1] = ~rd; end
      3'b010: begin v[4] = (k == 1); v[0] = ~wr; end
      default: v = IDLE_V;
    endcase
    return v;
  endfunction

  // called at a negedge with the design idle and status idle
  task automatic run_txn(logic [2:0] c, int hold, logic [2:0] after, string extra);
    int    m;
    string req;
    logic [4:0] o;
    m = (hold > 3) ? hold : 3;
    case (c)
      3'b110, 3'b010: req = "R3 R6";
      3'b101, 3'b001: req = "R4 R6";
      default:        req = "R7";
    endcase
    if (hold > 3 && c inside {3'b101, 3'b110, 3'b001, 3'b010}) req = {req, " R5"};
    req = {req, extra};
    status_i = c;
    for (int k = 1; k <= m + 3; k++) begin
      @(negedge clk_i);
      o = outs();
      check((k == 1) ? {req, " R2"} : req, o, expect_at(c, k, m));
      // R9 at most one strobe low
      n_run++;
      if ($countones(~o[3:0]) > 1 || (o[4] && o[3:0] != 4'hF)) begin
        n_fail++;
        $display("FAIL R9: outputs %b expected at most one active", o);
      end
      if (k == hold) status_i = after;
    end
    status_i = 3'b111;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    // R1 during reset
    status_i = 3'b111;
    repeat (3) @(negedge clk_i);
    check("R1", outs(), IDLE_V);
    // R8 code present at reset release starts nothing
    status_i = 3'b101;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", outs(), IDLE_V);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check("R8", outs(), IDLE_V);
    end
    status_i = 3'b111;
    repeat (2) @(negedge clk_i);

    // sweep every code and hold length
    for (int c = 0; c < 8; c++)
      for (int h = 1; h <= 6; h++)
        run_txn(3'(c), h, 3'b111, "");

    // R8 direct switch between command codes ends cycle, no restart
    run_txn(3'b110, 4, 3'b001, " R8");
    run_txn(3'b101, 5, 3'b010, " R8");
    run_txn(3'b001, 2, 3'b110, " R8");

    // R10 mid-cycle reset
    status_i = 3'b110;
    repeat (3) @(negedge clk_i);
    check("R10", outs(), 5'b01011);
    rst_ni = 1'b0;
    #0.5;
    check("R10", outs(), IDLE_V);
    @(negedge clk_i);
    status_i = 3'b111;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R10", outs(), IDLE_V);
    run_txn(3'b010, 3, 3'b111, " R10");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule